// File: doc/BRIEF.md
# DMA Transfer Descriptor Builder

This block turns one transfer request into the command descriptors that a DMA engine moving data between host memory and local memory consumes. A request carries a host address, a local address, a byte length and a direction bit. The block accepts a request with a valid/ready handshake. It then presents one or two 256-bit descriptors on a second valid/ready interface, one per handshake, and flags the final one as last.

Short transfers fit in a single line. Longer transfers become a multi-line descriptor made of equal 0x7000-byte lines, followed by a single remainder descriptor when the length is not a whole number of lines. Only the descriptor that finishes the transfer asks for a completion interrupt on the local side. A request of zero length is refused with a one-cycle error pulse.

Top module: `dma_desc_builder`

## Requirements
- R1: `req_ready_o` is high exactly when no descriptor is pending. A request is taken in a cycle where both `req_valid_i` and `req_ready_o` are high.
- R2: A length from 1 to 0x7FFF produces one descriptor. That descriptor has line count 1, host and local pitch 1, line size equal to the length, and last set.
- R3: A length above 0x7FFF produces a main descriptor. It has line size 0x7000, line count equal to length / 0x7000, and host and local pitch both 0x7000.
- R4: When length mod 0x7000 is nonzero, a second descriptor follows the main one. It has line count 1, pitch 1 and line size equal to the remainder. Its host and local addresses are both advanced by count×0x7000, the local address wrapping at 31 bits. Last is high only on this second descriptor.
- R5: Command bit 37 (local completion interrupt) is 1 on the final descriptor of a transfer and 0 on any earlier one.
- R6: The descriptor is four 64-bit words. Bits 63:0 hold the host address. The pitch word at bits 127:64 holds the local address in 30:0, the host pitch in 46:32 and the local pitch in 62:48. The command word at bits 191:128 holds the line size in 14:0 and the line count in 27:16. Bits 255:192 are zero.
- R7: Command bit 40 is set on every descriptor of a transfer when bits 63:32 of the host address, or of host address plus length, are nonzero.
- R8: Command bit 32 equals the request's upstream bit on every descriptor.
- R9: A zero-length request is consumed, produces no descriptor, and raises `err_o` for exactly the one cycle after acceptance.
- R10: While `desc_valid_o` is high and `desc_ready_i` is low, `desc_o` and `desc_last_o` hold their values.
- R11: During reset `req_ready_o` is 1, and `desc_valid_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_host_addr_i | input | 64 | Host start address |
| req_local_addr_i | input | 31 | Local start address |
| req_len_i | input | LEN_W (24) | Byte length |
| req_upstream_i | input | 1 | Direction: 1 = upstream |
| desc_valid_o | output | 1 | Descriptor valid |
| desc_ready_i | input | 1 | Descriptor ready |
| desc_o | output | 256 | Descriptor |
| desc_last_o | output | 1 | Final descriptor of the transfer |
| err_o | output | 1 | Zero-length rejection pulse |

## Verification
Two events can meet in one cycle. A new request can be waiting at the input in the same cycle that the consumer takes the final descriptor of the previous transfer. The bench keeps `req_valid_i` high across long random stalls on `desc_ready_i`, so that this handoff happens many times. The reference model then checks that the new request is taken only in the cycle after the last descriptor leaves. It also checks that a zero-length request sent straight after a split transfer gives its error pulse without disturbing the descriptor stream.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  localparam int HOST_W  = 64;
  localparam int LOC_W   = 31;
  localparam int SIZE_W  = 15;
  localparam int CNT_W   = 12;
  localparam int DESC_W  = 256;
  // command word bit positions (decoded by the engine)
  localparam int CMD_UP  = 32;
  localparam int CMD_IRQ = 37;
  localparam int CMD_B64 = 40;
  localparam int CMD_CNT = 16;
  // pitch word bit positions
  localparam int PIT_HOST = 32;
  localparam int PIT_LOC  = 48;

  typedef struct packed {
    logic [HOST_W-1:0] host;
    logic [LOC_W-1:0]  loc;
    logic [SIZE_W-1:0] pitch;
    logic [CNT_W-1:0]  cnt;
    logic [SIZE_W-1:0] size;
    logic              up;
    logic              irq;
    logic              b64;
  } desc_fields_t;

  typedef enum logic [1:0] {ST_IDLE, ST_MAIN, ST_REM} bld_state_e;
endpackage

// File: rtl/dma_desc_split.sv
module dma_desc_split
  import dma_desc_pkg::*;
#(
  parameter int LEN_W      = 24,
  parameter int LINE_BYTES = 28672
) (
  input  logic [LEN_W-1:0]  len_i,
  output logic              long_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [LEN_W-1:0]  adv_o,
  output logic [SIZE_W-1:0] rem_o
);
  localparam int SIZE_MAX = (1 << SIZE_W) - 1;

  logic [LEN_W-1:0] quot;

  assign quot   = len_i / LEN_W'(LINE_BYTES);
  assign adv_o  = LEN_W'(quot * LEN_W'(LINE_BYTES));
  assign cnt_o  = quot[CNT_W-1:0];
  assign rem_o  = SIZE_W'(len_i - adv_o);
  assign long_o = len_i > LEN_W'(SIZE_MAX);
endmodule

// File: rtl/dma_desc_pack.sv
module dma_desc_pack
  import dma_desc_pkg::*;
(
  input  desc_fields_t      fld_i,
  output logic [DESC_W-1:0] desc_o
);
  logic [63:0] pitch_w, cmd_w;

  always_comb begin
    pitch_w = '0;
    pitch_w[LOC_W-1:0]                = fld_i.loc;
    pitch_w[PIT_HOST +: SIZE_W]       = fld_i.pitch;
    pitch_w[PIT_LOC  +: SIZE_W]       = fld_i.pitch;
    cmd_w = '0;
    cmd_w[SIZE_W-1:0]                 = fld_i.size;
    cmd_w[CMD_CNT +: CNT_W]           = fld_i.cnt;
    cmd_w[CMD_UP]                     = fld_i.up;
    cmd_w[CMD_IRQ]                    = fld_i.irq;
    cmd_w[CMD_B64]                    = fld_i.b64;
  end

  assign desc_o = {64'd0, cmd_w, pitch_w, fld_i.host};
endmodule

// File: rtl/dma_desc_builder.sv
module dma_desc_builder
  import dma_desc_pkg::*;
#(
  parameter int LEN_W      = 24,
  parameter int LINE_BYTES = 28672
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [63:0]       req_host_addr_i,
  input  logic [30:0]       req_local_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_upstream_i,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [255:0]      desc_o,
  output logic              desc_last_o,
  output logic              err_o
);
  bld_state_e        state_q;
  logic [HOST_W-1:0] host_q;
  logic [LOC_W-1:0]  loc_q;
  logic [LEN_W-1:0]  len_q;
  logic              up_q, b64_q, err_q;

  logic              is_long, has_rem;
  logic [CNT_W-1:0]  cnt;
  logic [LEN_W-1:0]  adv;
  logic [SIZE_W-1:0] rem;
  logic [31:0]       end_hi;
  desc_fields_t      main_f, rem_f;
  logic [DESC_W-1:0] main_d, rem_d;

  assign end_hi = 32'((req_host_addr_i + HOST_W'(req_len_i)) >> 32);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      host_q  <= '0;
      loc_q   <= '0;
      len_q   <= '0;
      up_q    <= 1'b0;
      b64_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (req_len_i == '0) begin
            err_q <= 1'b1;
          end else begin
            host_q  <= req_host_addr_i;
            loc_q   <= req_local_addr_i;
            len_q   <= req_len_i;
            up_q    <= req_upstream_i;
            b64_q   <= (req_host_addr_i[63:32] != '0) || (end_hi != '0);
            state_q <= ST_MAIN;
          end
        end
        ST_MAIN: if (desc_ready_i) state_q <= has_rem ? ST_REM : ST_IDLE;
        ST_REM:  if (desc_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  dma_desc_split #(.LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_split (
    .len_i  (len_q),
    .long_o (is_long),
    .cnt_o  (cnt),
    .adv_o  (adv),
    .rem_o  (rem)
  );

  assign has_rem = is_long && (rem != '0);

  always_comb begin
    main_f.host  = host_q;
    main_f.loc   = loc_q;
    main_f.pitch = is_long ? SIZE_W'(LINE_BYTES) : SIZE_W'(1);
    main_f.cnt   = is_long ? cnt : CNT_W'(1);
    main_f.size  = is_long ? SIZE_W'(LINE_BYTES) : len_q[SIZE_W-1:0];
    main_f.up    = up_q;
    main_f.irq   = !has_rem;
    main_f.b64   = b64_q;

    rem_f.host   = host_q + HOST_W'(adv);
    rem_f.loc    = loc_q + LOC_W'(adv);
    rem_f.pitch  = SIZE_W'(1);
    rem_f.cnt    = CNT_W'(1);
    rem_f.size   = rem;
    rem_f.up     = up_q;
    rem_f.irq    = 1'b1;
    rem_f.b64    = b64_q;
  end

  dma_desc_pack u_pack_main (.fld_i(main_f), .desc_o(main_d));
  dma_desc_pack u_pack_rem  (.fld_i(rem_f),  .desc_o(rem_d));

  assign req_ready_o  = (state_q == ST_IDLE);
  assign desc_valid_o = (state_q != ST_IDLE);
  assign desc_last_o  = (state_q == ST_REM) || !has_rem;
  assign desc_o       = (state_q == ST_REM) ? rem_d : main_d;
  assign err_o        = err_q;
endmodule

// File: rtl/dma_desc_builder_chk.sv
module dma_desc_builder_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_valid_i,
  input logic         req_ready_o,
  input logic         desc_valid_o,
  input logic         desc_ready_i,
  input logic [255:0] desc_o,
  input logic         desc_last_o,
  input logic         err_o
);
  // R1
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o != desc_valid_o);

  // R10
  hold_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_o) && $stable(desc_last_o));

  // R5
  irq_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_o[165] == desc_last_o);

  // R4
  rem_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && desc_ready_i && !desc_last_o |=> desc_valid_o && desc_last_o);

  // R6
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_o[255:192] == 64'd0);

  // R9
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !desc_valid_o && $past(req_valid_i));

  // R2
  size_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_o[142:128] != 15'd0);
endmodule

bind dma_desc_builder dma_desc_builder_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .desc_valid_o (desc_valid_o),
  .desc_ready_i (desc_ready_i),
  .desc_o       (desc_o),
  .desc_last_o  (desc_last_o),
  .err_o        (err_o)
);

// File: tb/dma_desc_builder_tb.sv
module dma_desc_builder_tb;
  localparam int LEN_W = 24;
  localparam int LB    = 28672;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [63:0]       req_host = '0;
  logic [30:0]       req_loc = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              req_up = 1'b0;
  logic              desc_valid;
  logic              desc_ready = 1'b1;
  logic [255:0]      desc;
  logic              desc_last;
  logic              err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rdy_mode = 0;
  logic exp_err = 1'b0;
  logic stalled = 1'b0;

  logic [255:0] q_d[$];
  logic         q_last[$];
  string        q_tag[$];

  always #4 clk = ~clk;

  dma_desc_builder #(.LEN_W(LEN_W), .LINE_BYTES(LB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_host_addr_i(req_host), .req_local_addr_i(req_loc), .req_len_i(req_len),
    .req_upstream_i(req_up), .desc_valid_o(desc_valid), .desc_ready_i(desc_ready),
    .desc_o(desc), .desc_last_o(desc_last), .err_o(err)
  );

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(longint unsigned host, longint unsigned loc, int pitch,
                                      int cnt, int size, bit up, bit irq, bit b64);
    logic [255:0] d = '0;
    d[63:0]    = host;
    d[94:64]   = loc[30:0];
    d[110:96]  = pitch[14:0];
    d[126:112] = pitch[14:0];
    d[142:128] = size[14:0];
    d[155:144] = cnt[11:0];
    d[160]     = up;
    d[165]     = irq;
    d[168]     = b64;
    return d;
  endfunction

  task automatic model_push(longint unsigned host, longint unsigned loc, int len, bit up);
    longint unsigned endp = host + longint'(len);
    bit b64 = (host >> 32) != 0 || (endp >> 32) != 0;
    if (len <= 32767) begin
      q_d.push_back(mk(host, loc, 1, 1, len, up, 1'b1, b64)); q_last.push_back(1'b1); q_tag.push_back("R2");
    end else begin
      int cnt = len / LB;
      int rem = len % LB;
      q_d.push_back(mk(host, loc, LB, cnt, LB, up, rem == 0, b64));
      q_last.push_back(rem == 0); q_tag.push_back("R3");
      if (rem != 0) begin
        longint unsigned adv = longint'(cnt) * LB;
        q_d.push_back(mk(host + adv, loc + adv, 1, 1, rem, up, 1'b1, b64));
        q_last.push_back(1'b1); q_tag.push_back("R4");
      end
    end
  endtask

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q_d.delete(); q_last.delete(); q_tag.delete(); exp_err = 1'b0; stalled = 1'b0;
    end else begin
      exp_err = 1'b0;
      stalled = (q_d.size() > 0) && !desc_ready;
      if (q_d.size() > 0) begin
        if (desc_ready) begin
          void'(q_d.pop_front()); void'(q_last.pop_front()); void'(q_tag.pop_front());
        end
      end else if (req_valid) begin
        if (req_len == 0) exp_err = 1'b1;
        else model_push(req_host, {33'd0, req_loc}, int'(req_len), req_up);
      end
    end
  end

  // comparison shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R1", 256'(req_ready), 256'(q_d.size() == 0));
      chk("R9", 256'(err), 256'(exp_err));
      chk("R1", 256'(desc_valid), 256'(q_d.size() > 0));
      if (q_d.size() > 0) begin
        chk(stalled ? "R10" : q_tag[0], desc, q_d[0]);
        chk("R4", 256'(desc_last), 256'(q_last[0]));
        chk("R5", 256'(desc[165]), 256'(q_last[0]));
        chk("R7", 256'(desc[168]), 256'(q_d[0][168]));
        chk("R8", 256'(desc[160]), 256'(q_d[0][160]));
        chk("R6", desc[255:192], 256'd0);
      end
    end
  end

  always @(negedge clk) begin
    if (rdy_mode == 0) desc_ready <= 1'b1;
    else if (rdy_mode == 1) desc_ready <= ($urandom_range(0, 2) != 0);
    else desc_ready <= ($urandom_range(0, 4) == 0);
  end

  task automatic finish_tb();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_tb();
    end
  end

  task automatic send(longint unsigned host, int loc, int len, bit up);
    bit rs;
    @(negedge clk);
    req_valid = 1'b1; req_host = host; req_loc = loc[30:0];
    req_len = len[LEN_W-1:0]; req_up = up;
    forever begin
      rs = req_ready;
      @(negedge clk);
      if (rs) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_d.size() > 0 || desc_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #3;
    // R11 reset state
    chk("R11", 256'(req_ready), 256'd1);
    chk("R11", 256'(desc_valid), 256'd0);
    chk("R11", 256'(err), 256'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int m = 0; m < 3; m++) begin
      rdy_mode = m;
      send(64'h0000_0000_1000_0000, 32'h0000_4000, 0, 1'b0);        // R9
      send(64'h0000_0000_2000_0000, 32'h0000_0100, 1, 1'b1);        // R2
      send(64'h0000_0000_2000_1000, 32'h0000_0200, 32767, 1'b0);    // R2 boundary
      send(64'h0000_0000_3000_0000, 32'h0000_8000, 32768, 1'b1);    // R3/R4
      send(64'h0000_0000_3000_0000, 32'h0001_0000, 3 * LB, 1'b0);   // R3 exact
      send(64'h0000_0000_4000_0000, 32'h7FFF_F000, 2 * LB + 5, 1'b1); // R4 wrap
      send(64'h0000_0000_5000_0000, 32'h0000_0000, 0, 1'b1);        // R9 after split
      send(64'h0000_0000_FFFF_F000, 32'h0000_0040, 32'h2000, 1'b0); // R7 crossing
      send(64'h0000_0001_0000_0000, 32'h0000_0080, 64, 1'b1);       // R7 high
      send(64'h0000_0000_6000_0000, 32'h0000_0000, 24'hFFFFFF, 1'b0); // max length
      send(64'h0000_0000_7000_0000, 32'h0000_0000, LB, 1'b1);       // R2 single line
      drain();
    end
    for (int i = 0; i < 40; i++) begin
      rdy_mode = 1;
      send({32'd0, $urandom()}, $urandom(), $urandom_range(0, 200000), $urandom_range(0, 1) == 1);
    end
    drain();
    finish_tb();
  end
endmodule